// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a memory-style device. A test clock, a mode-select line and a serial data input walk a sixteen-state controller. The controller routes serial data through one of three registers: a 3-bit instruction register, a 1-bit bypass stage or a 32-bit identification word. The boundary register itself lives outside the block. For that register the block gives a select level, capture, shift and update strobes, and it multiplexes the boundary register's serial output onto the test data output.

The instruction set has eight codes. Three of them place the boundary register in the scan path, one of those also tells the pin logic to float every device output, one selects the identification word, and the other four select the bypass stage. The device-side logic reads the strobes and the float request. Test equipment uses only the four serial pins and the enable of the data output.

Top module: `scan_tap`

## Requirements
- R1: The controller follows the standard sixteen-state transition graph on each rising test-clock edge. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state, and four such edges from Shift-DR are not enough.
- R2: Entering Test-Logic-Reset makes IDCODE (code 001) the current instruction, so the next data scan returns the identification word.
- R3: In Capture-IR the instruction shift register loads 001. During Shift-IR it shifts toward `tdo` least significant bit first, and new bits enter at the top from `tdi`.
- R4: Decode: 001 selects the identification word. 000, 010 and 100 select the boundary register. 111, 011, 101 and 110 select the bypass stage. A shifted code becomes the current instruction on the rising edge that leaves Update-IR.
- R5: The identification word is 0xA000E021: bits 31..28 are 1010, bits 27..12 are 0x000E, bits 11..1 are 00000010000 and bit 0 is 1. It is loaded in Capture-DR and shifted out least significant bit first.
- R6: The bypass stage loads 0 in Capture-DR and delays `tdi` by one stage in Shift-DR.
- R7: `bnd_sel` is high while a boundary instruction is current. `bnd_capture`, `bnd_shift` and `bnd_update` are high in Capture-DR, Shift-DR and Update-DR respectively, and only when `bnd_sel` is high. At most one of the three is high at a time.
- R8: `pins_float` is high exactly while code 010 is the current instruction.
- R9: `tdo` and `tdo_oe` change only on the falling test-clock edge. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.
- R10: In Shift-DR with a boundary instruction, `tdo` carries the value of `bnd_so`.
- R11: `rst` is a synchronous active-high reset. It places the controller in Test-Logic-Reset and makes IDCODE current, with `tdo_oe`, `pins_float` and `bnd_sel` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| bnd_so | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Enable of the serial data output |
| bnd_sel | output | 1 | Boundary register is in the scan path |
| bnd_capture | output | 1 | Boundary register capture strobe |
| bnd_shift | output | 1 | Boundary register shift strobe |
| bnd_update | output | 1 | Boundary register update strobe |
| pins_float | output | 1 | Request to float all device outputs |

## Verification
A controller stuck in the wrong state shows at the next falling edge as a wrong `tdo_oe`, or as a strobe in the wrong place. A current instruction that is wrong shows at once on `pins_float` and `bnd_sel` after Update-IR. It also changes the next data scan: an identification word, a bypass pattern shifted by one bit, or a copy of `bnd_so`. Shift-register faults corrupt the serial stream within one scan of 3 or 32 bits, and a wrong reset path shows after the fifth `tms`-high edge.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    localparam logic [3:0]  ID_VERSION = 4'b1010;
    localparam logic [15:0] ID_PART    = 16'h000E;
    localparam logic [10:0] ID_MAKER   = 11'b000_0001_0000;

    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST  = 3'b000,
        OP_IDCODE  = 3'b001,
        OP_SAMPLEZ = 3'b010,
        OP_PRIV_A  = 3'b011,
        OP_SAMPLE  = 3'b100,
        OP_PRIV_B  = 3'b101,
        OP_PRIV_C  = 3'b110,
        OP_BYPASS  = 3'b111
    } tap_op_e;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_IDENT,
        PATH_BOUND
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     float_pins;
    } op_decode_t;

    function automatic logic [ID_W-1:0] ident_word();
        return {ID_VERSION, ID_PART, ID_MAKER, 1'b1};
    endfunction

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        tap_state_e n;
        n = ST_RESET;
        case (s)
            ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic op_decode_t decode_op(logic [IR_W-1:0] op);
        op_decode_t d;
        d.float_pins = 1'b0;
        d.path       = PATH_BYPASS;
        case (tap_op_e'(op))
            OP_IDCODE:  d.path = PATH_IDENT;
            OP_EXTEST:  d.path = PATH_BOUND;
            OP_SAMPLE:  d.path = PATH_BOUND;
            OP_SAMPLEZ: begin
                d.path       = PATH_BOUND;
                d.float_pins = 1'b1;
            end
            default:    d.path = PATH_BYPASS;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state,
    output tap_state_e state_nxt
);

    always_comb state_nxt = tap_next(state, tms);

    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= state_nxt;
    end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
#(
    parameter int W = IR_W
) (
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_e state,
    input  tap_state_e state_nxt,
    output logic       ir_so,
    output op_decode_t dec
);

    logic [W-1:0] shreg;
    logic [W-1:0] cur_op;

    always_ff @(posedge tck) begin
        if (rst) begin
            shreg  <= IR_CAPTURE_PAT;
            cur_op <= OP_IDCODE;
        end else begin
            case (state)
                ST_CAP_IR: shreg <= IR_CAPTURE_PAT;
                ST_SH_IR:  shreg <= {tdi, shreg[W-1:1]};
                default:   shreg <= shreg;
            endcase
            if (state_nxt == ST_RESET)
                cur_op <= OP_IDCODE;
            else if (state == ST_UPD_IR)
                cur_op <= shreg;
        end
    end

    assign ir_so = shreg[0];
    assign dec   = decode_op(cur_op);

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int IDW = ID_W
) (
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_e state,
    input  op_decode_t dec,
    input  logic       ir_so,
    input  logic       bnd_so,
    output logic       tdo,
    output logic       tdo_oe,
    output logic       bnd_sel,
    output logic       bnd_capture,
    output logic       bnd_shift,
    output logic       bnd_update
);

    localparam logic [IDW-1:0] ID_VALUE = ident_word();

    logic           byp_q;
    logic [IDW-1:0] id_q;
    logic           tdo_q;
    logic           oe_q;
    logic           dr_bit;

    assign bnd_sel     = (dec.path == PATH_BOUND);
    assign bnd_capture = bnd_sel && (state == ST_CAP_DR);
    assign bnd_shift   = bnd_sel && (state == ST_SH_DR);
    assign bnd_update  = bnd_sel && (state == ST_UPD_DR);

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q <= 1'b0;
            id_q  <= ID_VALUE;
        end else begin
            case (state)
                ST_CAP_DR: begin
                    byp_q <= 1'b0;
                    id_q  <= ID_VALUE;
                end
                ST_SH_DR: begin
                    byp_q <= tdi;
                    id_q  <= {tdi, id_q[IDW-1:1]};
                end
                default: begin
                    byp_q <= byp_q;
                    id_q  <= id_q;
                end
            endcase
        end
    end

    always_comb begin
        case (dec.path)
            PATH_IDENT: dr_bit = id_q[0];
            PATH_BOUND: dr_bit = bnd_so;
            default:    dr_bit = byp_q;
        endcase
    end

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q <= (state == ST_SH_DR) || (state == ST_SH_IR);
            case (state)
                ST_SH_IR: tdo_q <= ir_so;
                ST_SH_DR: tdo_q <= dr_bit;
                default:  tdo_q <= 1'b0;
            endcase
        end
    end

    assign tdo    = tdo_q;
    assign tdo_oe = oe_q;

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
(
    input  logic tck,
    input  logic rst,
    input  logic tms,
    input  logic tdi,
    input  logic bnd_so,
    output logic tdo,
    output logic tdo_oe,
    output logic bnd_sel,
    output logic bnd_capture,
    output logic bnd_shift,
    output logic bnd_update,
    output logic pins_float
);

    tap_state_e fsm_state;
    tap_state_e fsm_nxt;
    op_decode_t op_dec;
    logic       ir_serial;

    scan_tap_fsm u_fsm (
        .tck       (tck),
        .rst       (rst),
        .tms       (tms),
        .state     (fsm_state),
        .state_nxt (fsm_nxt)
    );

    scan_tap_ir #(.W(IR_W)) u_ir (
        .tck       (tck),
        .rst       (rst),
        .tdi       (tdi),
        .state     (fsm_state),
        .state_nxt (fsm_nxt),
        .ir_so     (ir_serial),
        .dec       (op_dec)
    );

    scan_tap_dr #(.IDW(ID_W)) u_dr (
        .tck         (tck),
        .rst         (rst),
        .tdi         (tdi),
        .state       (fsm_state),
        .dec         (op_dec),
        .ir_so       (ir_serial),
        .bnd_so      (bnd_so),
        .tdo         (tdo),
        .tdo_oe      (tdo_oe),
        .bnd_sel     (bnd_sel),
        .bnd_capture (bnd_capture),
        .bnd_shift   (bnd_shift),
        .bnd_update  (bnd_update)
    );

    assign pins_float = op_dec.float_pins;

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
    import scan_tap_pkg::*;
(
    input logic       tck,
    input logic       rst,
    input logic       tms,
    input logic       tdo_oe,
    input logic       pins_float,
    input logic       bnd_sel,
    input logic       bnd_capture,
    input logic       bnd_shift,
    input logic       bnd_update,
    input tap_state_e cur_state
);

    logic [2:0] hi_run;

    always_ff @(posedge tck) begin
        if (rst)                    hi_run <= 3'd0;
        else if (!tms)              hi_run <= 3'd0;
        else if (hi_run != 3'd7)    hi_run <= hi_run + 3'd1;
    end

    // R7
    strobe_excl_chk: assert property (@(posedge tck) disable iff (rst)
        $onehot0({bnd_capture, bnd_shift, bnd_update}));

    // R7
    strobe_sel_chk: assert property (@(posedge tck) disable iff (rst)
        (bnd_capture || bnd_shift || bnd_update) |-> bnd_sel);

    // R8
    float_sel_chk: assert property (@(posedge tck) disable iff (rst)
        pins_float |-> bnd_sel);

    // R1
    tms_reset_chk: assert property (@(posedge tck) disable iff (rst)
        (hi_run >= 3'd5) |-> (cur_state == ST_RESET && !pins_float && !bnd_sel));

    // R9
    oe_state_chk: assert property (@(posedge tck) disable iff (rst)
        tdo_oe == (cur_state == ST_SH_DR || cur_state == ST_SH_IR));

    // R4
    float_hold_chk: assert property (@(posedge tck) disable iff (rst)
        (!tms && cur_state != ST_UPD_IR) |=> $stable(pins_float));

endmodule

bind scan_tap scan_tap_chk u_chk (
    .tck         (tck),
    .rst         (rst),
    .tms         (tms),
    .tdo_oe      (tdo_oe),
    .pins_float  (pins_float),
    .bnd_sel     (bnd_sel),
    .bnd_capture (bnd_capture),
    .bnd_shift   (bnd_shift),
    .bnd_update  (bnd_update),
    .cur_state   (fsm_state)
);

// File: tb/scan_tap_bench.sv
`timescale 1ns/1ps
module scan_tap_bench;

    localparam int T_CLK = 100;
    localparam logic [31:0] EXP_ID  = 32'hA000_E021;
    localparam logic [31:0] PAT_IN  = 32'h5A3C_C3A5;

    // {opcode[2:0], path[1:0] (0 bypass,1 ident,2 boundary), float}
    localparam logic [5:0] VEC [8] = '{
        {3'b000, 2'd2, 1'b0},
        {3'b001, 2'd1, 1'b0},
        {3'b010, 2'd2, 1'b1},
        {3'b011, 2'd0, 1'b0},
        {3'b100, 2'd2, 1'b0},
        {3'b101, 2'd0, 1'b0},
        {3'b110, 2'd0, 1'b0},
        {3'b111, 2'd0, 1'b0}
    };

    logic tck = 1'b0;
    logic rst, tms, tdi, bnd_so;
    logic tdo, tdo_oe, bnd_sel, bnd_capture, bnd_shift, bnd_update, pins_float;
    int   n_cmp = 0;
    int   n_bad = 0;

    scan_tap u_scan_tap (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .bnd_so(bnd_so),
        .tdo(tdo), .tdo_oe(tdo_oe), .bnd_sel(bnd_sel), .bnd_capture(bnd_capture),
        .bnd_shift(bnd_shift), .bnd_update(bnd_update), .pins_float(pins_float)
    );

    always #(T_CLK/2) tck = ~tck;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
        o = tdo;
    endtask

    // from Run-Test/Idle to Run-Test/Idle; returns the captured IR bits
    task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
        logic o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o);
        step(0, 0, o); cap[0] = o;
        step(0, op[0], o); cap[1] = o;
        step(0, op[1], o); cap[2] = o;
        step(1, op[2], o);
        step(1, 0, o);
        step(0, 0, o);
    endtask

    task automatic scan_dr(input logic [31:0] din, output logic [31:0] dout,
                           output logic [3:0] strb);
        logic o;
        step(1, 0, o);
        step(0, 0, o);
        strb[0] = bnd_capture;
        step(0, 0, o);
        dout[0] = o;
        strb[1] = bnd_shift;
        strb[3] = tdo_oe;
        for (int i = 0; i < 31; i++) begin
            step(0, din[i], o);
            dout[i+1] = o;
        end
        step(1, din[31], o);
        step(1, 0, o);
        strb[2] = bnd_update;
        step(0, 0, o);
    endtask

    initial begin
        #(T_CLK * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [2:0]  cap;
        logic [31:0] dout;
        logic [31:0] exp;
        logic [3:0]  strb;
        logic        o;
        logic        o2;

        rst = 1'b1; tms = 1'b1; tdi = 1'b0; bnd_so = 1'b1;
        repeat (3) @(negedge tck);
        #1;
        // R11 reset state
        check("R11 tdo_oe", {31'd0, tdo_oe}, 32'd0);
        check("R11 pins_float", {31'd0, pins_float}, 32'd0);
        check("R11 bnd_sel", {31'd0, bnd_sel}, 32'd0);
        rst = 1'b0;
        step(0, 0, o);
        check("R9 oe low in idle", {31'd0, tdo_oe}, 32'd0);

        // R2 R5 first data scan after reset returns the ID word
        scan_dr(PAT_IN, dout, strb);
        check("R5 ident after reset", dout, EXP_ID);

        // vector table: every opcode
        foreach (VEC[k]) begin
            load_ir(VEC[k][5:3], cap);
            check("R3 capture-IR pattern", {29'd0, cap}, 32'd1);
            check("R8 pins_float", {31'd0, pins_float}, {31'd0, VEC[k][0]});
            check("R7 bnd_sel", {31'd0, bnd_sel}, {31'd0, VEC[k][2:1] == 2'd2});
            scan_dr(PAT_IN, dout, strb);
            case (VEC[k][2:1])
                2'd1:    exp = EXP_ID;
                2'd2:    exp = 32'hFFFF_FFFF;
                default: exp = {PAT_IN[30:0], 1'b0};
            endcase
            // R4 R5 R6 R10 path selected by opcode
            check("R4 data path content", dout, exp);
            check("R7 strobes", {28'd0, strb[2:0] == 3'b111 ? 4'd7 : {1'b0, strb[2:0]}},
                  (VEC[k][2:1] == 2'd2) ? 32'd7 : 32'd0);
            check("R9 oe in shift", {31'd0, strb[3]}, 32'd1);
            check("R9 oe after exit", {31'd0, tdo_oe}, 32'd0);
        end

        // R10 boundary output follows bnd_so = 0
        bnd_so = 1'b0;
        load_ir(3'b100, cap);
        scan_dr(PAT_IN, dout, strb);
        check("R10 bnd_so low", dout, 32'd0);
        bnd_so = 1'b1;

        // R9 tdo changes only at the falling edge (bypass path)
        load_ir(3'b111, cap);
        step(1, 0, o); step(0, 0, o);
        step(0, 0, o);
        check("R6 bypass captures 0", {31'd0, o}, 32'd0);
        tms = 1'b0; tdi = 1'b1;
        @(posedge tck); #1;
        o2 = tdo;
        check("R9 tdo held after rising edge", {31'd0, o2}, 32'd0);
        @(negedge tck); #1;
        check("R9 tdo new bit after falling edge", {31'd0, tdo}, 32'd1);
        step(1, 0, o); step(1, 0, o); step(0, 0, o);

        // R1 R2 five TMS-high edges from Shift-DR
        load_ir(3'b010, cap);
        check("R8 SAMPLEZ float", {31'd0, pins_float}, 32'd1);
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        repeat (4) step(1, 0, o);
        check("R1 four highs not reset", {31'd0, pins_float}, 32'd1);
        step(1, 0, o);
        check("R1 five highs reset float", {31'd0, pins_float}, 32'd0);
        check("R2 five highs reset sel", {31'd0, bnd_sel}, 32'd0);
        step(0, 0, o);
        scan_dr(PAT_IN, dout, strb);
        check("R2 ident after TMS reset", dout, EXP_ID);

        // R1 from Pause-IR mid-load, with a bypass code half shifted
        load_ir(3'b000, cap);
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        step(0, 1, o); step(1, 1, o); step(0, 0, o);
        repeat (5) step(1, 0, o);
        step(0, 0, o);
        scan_dr(PAT_IN, dout, strb);
        check("R1 reset from Pause-IR", dout, EXP_ID);

        // R11 synchronous reset from a boundary instruction
        load_ir(3'b010, cap);
        rst = 1'b1;
        @(posedge tck); @(negedge tck); #1;
        check("R11 float cleared", {31'd0, pins_float}, 32'd0);
        rst = 1'b0;
        step(0, 0, o);
        scan_dr(PAT_IN, dout, strb);
        check("R11 ident after rst", dout, EXP_ID);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule